// File: doc/BRIEF.md
# Multicycle 32-bit Load/Store Processor Core

This block is a small processor core that runs a fixed-length 32-bit instruction set out of one unified word memory. It has 32 general registers, and the last of them is hardwired to zero. It runs arithmetic, logic, compare and shift operations in two forms: one takes two registers and the other takes a register and a sign-extended 16-bit constant. It also runs word loads and stores with a base-plus-displacement address, and two conditional branches that save a link value.

Each instruction goes through a short state sequence: fetch, decode, execute, and for loads a final write-back. One synchronous memory port carries both instruction and data traffic, and read data comes back one cycle after the address is presented. When the core meets an opcode it does not recognize, it stops and holds a halt flag until the next reset.

Top module: `cpu_core`

## Requirements
- R1: While `rst_n` is low, `halted` and `mem_we` are 0 and `mem_addr` is 0. The first instruction is fetched from byte address 0.
- R2: Each instruction is fetched from `mem_addr` = PC. Read data arrives one cycle later, and PC then advances by 4 before the instruction executes.
- R3: Instruction fields are opcode [31:26], rc [25:21], ra [20:16], rb [15:11] and literal [15:0]. The opcode 6'b10ffff selects the register form of ALU function f, and 6'b11ffff selects the constant form. f takes 0 ADD, 1 SUB, 2 MUL, 3 DIV, 4 CMPEQ, 5 CMPLT, 6 CMPLE, 7 AND, 8 OR, 9 XOR, 10 SHL, 11 SHR, 12 SAR. The other opcodes are 0x18 load, 0x19 store, 0x1C branch-if-zero and 0x1D branch-if-nonzero.
- R4: ADD, SUB and MUL return the low 32 bits of the result. DIV is a signed division, and a zero divisor gives 0. All four write Reg[rc].
- R5: The constant forms use the sign-extended 16-bit literal in place of Reg[rb].
- R6: CMPEQ, CMPLT and CMPLE write 1 when the relation holds and 0 when it does not. CMPLT and CMPLE compare signed values.
- R7: AND, OR and XOR work bitwise. The shift amount is the low 5 bits of the second operand. SHL and SHR fill with zeros, and SAR fills with the sign bit.
- R8: A load writes Reg[rc] with the memory word at Reg[ra] + sxt(literal). Address bits [1:0] are cleared on `mem_addr`.
- R9: A store writes Reg[rc] to the word at Reg[ra] + sxt(literal), with address bits [1:0] cleared. `mem_we` is high for that single cycle only.
- R10: Branch-if-zero and branch-if-nonzero test Reg[ra]. When the branch is taken, PC becomes (PC+4) + 4*sxt(literal). Reg[rc] receives PC+4 whether or not the branch is taken.
- R11: Register 31 always reads as 0 and writes to it are lost, so a base of register 31 gives absolute addressing.
- R12: An unrecognized opcode raises `halted`. The flag stays high until reset, and no later instruction writes memory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 32 | Byte address for instruction fetch or data access |
| mem_wdata | output | 32 | Store data |
| mem_we | output | 1 | Write strobe for one cycle |
| mem_rdata | input | 32 | Read data, valid one cycle after the address |
| halted | output | 1 | Core stopped on an unrecognized opcode |

## Verification
The bench aims at signed arithmetic edges: a zero divisor, negative operands against signed compares, and arithmetic shifts of negative values. A core that compared unsigned values, or shifted by more than five bits, would store the wrong result word. Literals with bit 15 set test sign extension, which a zero-extending core would get wrong. Loads and stores with misaligned displacements would land on the wrong word if the low address bits were not dropped. Forward, backward and not-taken branches test the target arithmetic and the link value. A wrong target either loops until timeout or skips a marker instruction. Writes to register 31 and a store placed after an illegal opcode must leave their observed words unchanged.

// File: rtl/cpu_pkg.sv
package cpu_pkg;
   typedef enum logic [2:0] {
      ST_FETCH,
      ST_DECODE,
      ST_EXEC,
      ST_LOAD,
      ST_HALT
   } cpu_state_e;

   typedef enum logic [3:0] {
      FN_ADD   = 4'd0,
      FN_SUB   = 4'd1,
      FN_MUL   = 4'd2,
      FN_DIV   = 4'd3,
      FN_CMPEQ = 4'd4,
      FN_CMPLT = 4'd5,
      FN_CMPLE = 4'd6,
      FN_AND   = 4'd7,
      FN_OR    = 4'd8,
      FN_XOR   = 4'd9,
      FN_SHL   = 4'd10,
      FN_SHR   = 4'd11,
      FN_SAR   = 4'd12
   } alu_fn_e;

   localparam logic [3:0] FN_LAST  = 4'd12;
   localparam logic [5:0] OPC_LD   = 6'h18;
   localparam logic [5:0] OPC_ST   = 6'h19;
   localparam logic [5:0] OPC_BEQ  = 6'h1C;
   localparam logic [5:0] OPC_BNE  = 6'h1D;
endpackage

// File: rtl/cpu_alu.sv
module cpu_alu
   import cpu_pkg::*;
#(
   parameter int W = 32
) (
   input  alu_fn_e        fn,
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   output logic [W-1:0]   y
);
   localparam int SH_W = $clog2(W);

   logic [SH_W-1:0] sh;
   assign sh = b[SH_W-1:0];

   always_comb begin
      y = '0;
      case (fn)
         FN_ADD:   y = a + b;
         FN_SUB:   y = a - b;
         FN_MUL:   y = a * b;
         FN_DIV: begin
            if (b == '0) y = '0;
            else         y = $signed(a) / $signed(b);
         end
         FN_CMPEQ: y = {{(W-1){1'b0}}, (a == b)};
         FN_CMPLT: y = {{(W-1){1'b0}}, ($signed(a) <  $signed(b))};
         FN_CMPLE: y = {{(W-1){1'b0}}, ($signed(a) <= $signed(b))};
         FN_AND:   y = a & b;
         FN_OR:    y = a | b;
         FN_XOR:   y = a ^ b;
         FN_SHL:   y = a << sh;
         FN_SHR:   y = a >> sh;
         FN_SAR:   y = $signed(a) >>> sh;
         default:  y = '0;
      endcase
   end
endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
   parameter int W  = 32,
   parameter int AW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] wa,
   input  logic [W-1:0]  wd,
   input  logic [AW-1:0] ra_a,
   output logic [W-1:0]  rd_a,
   input  logic [AW-1:0] ra_b,
   output logic [W-1:0]  rd_b
);
   localparam int N = 1 << AW;

   logic [W-1:0] regs [N];

   for (genvar i = 0; i < N - 1; i++) begin : g_reg
      logic [W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                       q <= '0;
         else if (we && (wa == AW'(i)))    q <= wd;
      end
      assign regs[i] = q;
   end

   // top entry has no storage: it reads zero and drops writes
   assign regs[N-1] = '0;

   assign rd_a = regs[ra_a];
   assign rd_b = regs[ra_b];
endmodule

// File: rtl/cpu_core.sv
module cpu_core
   import cpu_pkg::*;
#(
   parameter int                 DATA_W   = 32,
   parameter int                 REG_AW   = 5,
   parameter logic [DATA_W-1:0]  RESET_PC = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [DATA_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_we,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              halted
);
   localparam int LIT_W = 16;
   localparam logic [DATA_W-1:0] STEP = DATA_W'(4);
   localparam logic [DATA_W-1:0] WORD_MASK = ~DATA_W'(3);

   if (DATA_W != 32) begin : g_chk_w
      $error("cpu_core: DATA_W must be 32 for the fixed instruction layout");
   end
   if (REG_AW != 5) begin : g_chk_r
      $error("cpu_core: REG_AW must be 5 to match the register fields");
   end
   if (RESET_PC[1:0] != 2'b00) begin : g_chk_pc
      $error("cpu_core: RESET_PC must be word aligned");
   end

   cpu_state_e        state;
   logic [DATA_W-1:0] pc;
   logic [DATA_W-1:0] ir;

   logic [5:0]        f_op;
   logic [REG_AW-1:0] f_rc, f_ra, f_rb;
   logic [LIT_W-1:0]  f_lit;
   logic [DATA_W-1:0] simm;

   assign f_op  = ir[31:26];
   assign f_rc  = ir[25:21];
   assign f_ra  = ir[20:16];
   assign f_rb  = ir[15:11];
   assign f_lit = ir[15:0];
   assign simm  = {{(DATA_W-LIT_W){f_lit[LIT_W-1]}}, f_lit};

   logic is_alu, is_cform, is_ld, is_st, is_beq, is_bne, is_br, is_legal;
   assign is_alu   = f_op[5] && (f_op[3:0] <= FN_LAST);
   assign is_cform = f_op[4];
   assign is_ld    = (f_op == OPC_LD);
   assign is_st    = (f_op == OPC_ST);
   assign is_beq   = (f_op == OPC_BEQ);
   assign is_bne   = (f_op == OPC_BNE);
   assign is_br    = is_beq || is_bne;
   assign is_legal = is_alu || is_ld || is_st || is_br;

   logic              rf_we;
   logic [DATA_W-1:0] rf_wd, rd_a, rd_b;
   logic [REG_AW-1:0] rb_sel;

   assign rb_sel = is_st ? f_rc : f_rb;

   cpu_regfile #(.W(DATA_W), .AW(REG_AW)) u_rf (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (rf_we),
      .wa   (f_rc),
      .wd   (rf_wd),
      .ra_a (f_ra),
      .rd_a (rd_a),
      .ra_b (rb_sel),
      .rd_b (rd_b)
   );

   logic [DATA_W-1:0] alu_b, alu_y;
   assign alu_b = is_cform ? simm : rd_b;

   cpu_alu #(.W(DATA_W)) u_alu (
      .fn(alu_fn_e'(f_op[3:0])),
      .a (rd_a),
      .b (alu_b),
      .y (alu_y)
   );

   logic [DATA_W-1:0] ea, br_target;
   logic              br_taken;
   assign ea        = rd_a + simm;
   assign br_target = pc + (simm << 2);
   assign br_taken  = is_beq ? (rd_a == '0) : (rd_a != '0);

   logic in_exec;
   assign in_exec = (state == ST_EXEC);

   assign rf_we = (in_exec && (is_alu || is_br)) || (state == ST_LOAD);
   assign rf_wd = (state == ST_LOAD) ? mem_rdata : (is_br ? pc : alu_y);

   assign mem_addr  = (in_exec && (is_ld || is_st)) ? (ea & WORD_MASK) : pc;
   assign mem_wdata = rd_b;
   assign mem_we    = in_exec && is_st;
   assign halted    = (state == ST_HALT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_FETCH;
         pc    <= RESET_PC;
         ir    <= '0;
      end else begin
         case (state)
            ST_FETCH:  state <= ST_DECODE;
            ST_DECODE: begin
               ir    <= mem_rdata;
               pc    <= pc + STEP;
               state <= ST_EXEC;
            end
            ST_EXEC: begin
               if (!is_legal)      state <= ST_HALT;
               else if (is_ld)     state <= ST_LOAD;
               else begin
                  if (is_br && br_taken) pc <= br_target;
                  state <= ST_FETCH;
               end
            end
            ST_LOAD:   state <= ST_FETCH;
            default:   state <= ST_HALT;
         endcase
      end
   end
endmodule

// File: rtl/cpu_core_chk.sv
module cpu_core_chk
   import cpu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int REG_AW = 5
) (
   input logic              clk,
   input logic              rst_n,
   input cpu_state_e        state,
   input logic [DATA_W-1:0] pc,
   input logic              mem_we,
   input logic [DATA_W-1:0] mem_addr,
   input logic              halted,
   input logic [REG_AW-1:0] rf_ra_idx,
   input logic [DATA_W-1:0] rf_ra_val
);
   AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DECODE) |=> (pc == $past(pc) + DATA_W'(4))); // R2

   AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted); // R12

   AST_HALT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !mem_we); // R12

   AST_WE_IN_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (state == ST_EXEC)); // R9

   AST_WE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_addr[1:0] == 2'b00)); // R9

   AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we); // R9

   AST_ZERO_REG: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_ra_idx == {REG_AW{1'b1}}) |-> (rf_ra_val == '0)); // R11
endmodule

bind cpu_core cpu_core_chk #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .state    (state),
   .pc       (pc),
   .mem_we   (mem_we),
   .mem_addr (mem_addr),
   .halted   (halted),
   .rf_ra_idx(f_ra),
   .rf_ra_val(rd_a)
);

// File: tb/sim_cpu_core.sv
module sim_cpu_core;
   localparam int CLK_PERIOD = 10;
   localparam int SEED       = 24681;
   localparam int RUN_LIMIT  = 3000;
   localparam int WATCHDOG   = 150000;

   localparam logic [5:0] OP_LD  = 6'h18;
   localparam logic [5:0] OP_ST  = 6'h19;
   localparam logic [5:0] OP_BEQ = 6'h1C;
   localparam logic [5:0] OP_BNE = 6'h1D;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic        mem_we, halted;
   logic [31:0] mem [256];

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
      mem_rdata <= mem[mem_addr[9:2]];
   end

   cpu_core u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .mem_addr (mem_addr),
      .mem_wdata(mem_wdata),
      .mem_we   (mem_we),
      .mem_rdata(mem_rdata),
      .halted   (halted)
   );

   int checks = 0;
   int errors = 0;
   int halt_we = 0;
   bit done = 1'b0;

   always @(negedge clk) if (rst_n && halted && mem_we) halt_we++;

   task automatic check(string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", what, act, exp);
      end
   endtask

   function automatic logic [31:0] enc_r(logic [5:0] op, int rc, int ra, int rb);
      return {op, rc[4:0], ra[4:0], rb[4:0], 11'b0};
   endfunction

   function automatic logic [31:0] enc_c(logic [5:0] op, int rc, int ra, logic [15:0] lit);
      return {op, rc[4:0], ra[4:0], lit};
   endfunction

   function automatic logic [31:0] ref_alu(int fn, logic [31:0] a, logic [31:0] b);
      logic [31:0] r;
      logic [4:0]  s;
      s = b[4:0];
      r = '0;
      case (fn)
         0: r = a + b;
         1: r = a - b;
         2: r = a * b;
         3: begin
            if (b == 0) r = 0;
            else        r = $signed(a) / $signed(b);
         end
         4: r = (a == b) ? 32'd1 : 32'd0;
         5: r = ($signed(a) <  $signed(b)) ? 32'd1 : 32'd0;
         6: r = ($signed(a) <= $signed(b)) ? 32'd1 : 32'd0;
         7: r = a & b;
         8: r = a | b;
         9: r = a ^ b;
         10: r = a << s;
         11: r = a >> s;
         12: begin
            r = a >> s;
            if (a[31]) r = r | ~(32'hFFFF_FFFF >> s);
         end
         default: r = '0;
      endcase
      return r;
   endfunction

   function automatic string fn_tag(int fn);
      if (fn <= 3)      return "R4";
      else if (fn <= 6) return "R6";
      else              return "R7";
   endfunction

   task automatic begin_prog();
      rst_n = 1'b0;
      @(negedge clk);
      for (int i = 0; i < 256; i++) mem[i] = 32'h0;
   endtask

   task automatic run_prog();
      int cyc;
      @(negedge clk);
      check("R1 reset address", mem_addr, 32'h0);
      check("R1 reset flags", {30'b0, halted, mem_we}, 32'h0);
      rst_n = 1'b1;
      cyc = 0;
      while (!halted && cyc < RUN_LIMIT) begin
         @(negedge clk);
         cyc++;
      end
      if (!halted) check("R12 run did not halt", 32'd0, 32'd1);
   endtask

   initial begin
      int dummy;
      logic [31:0] a, b;
      logic [15:0] lit;
      dummy = $urandom(SEED);

      // R3 R4 R5 R6 R7: each function in register and constant form
      for (int fn = 0; fn < 13; fn++) begin
         for (int t = 0; t < 6; t++) begin
            a = $urandom;
            b = $urandom;
            lit = 16'($urandom);
            case (t)
               0: begin b = 0; lit = 16'h0; end
               1: begin b = $urandom % 40; lit = 16'($urandom % 40); end
               2: begin a = 32'hFFFF_FF00 | ($urandom & 32'hFF); lit = 16'h8000 | 16'($urandom); end
               3: begin b = a; lit = a[15:0]; end
               4: begin a = 32'h8000_0000; b = 32'h7FFF_FFFF; lit = 16'hFFFF; end
               default: ;
            endcase
            begin_prog();
            mem[0]   = enc_c(OP_LD, 1, 31, 16'h0200);
            mem[1]   = enc_c(OP_LD, 2, 31, 16'h0204);
            mem[2]   = enc_r(6'h20 | 6'(fn), 3, 1, 2);
            mem[3]   = enc_c(OP_ST, 3, 31, 16'h0300);
            mem[4]   = enc_c(6'h30 | 6'(fn), 4, 1, lit);
            mem[5]   = enc_c(OP_ST, 4, 31, 16'h0304);
            mem[128] = a;
            mem[129] = b;
            run_prog();
            check($sformatf("%s register form fn %0d", fn_tag(fn), fn), mem[192], ref_alu(fn, a, b));
            check($sformatf("R5 constant form fn %0d", fn), mem[193],
                  ref_alu(fn, a, {{16{lit[15]}}, lit}));
         end
      end

      // R8: misaligned displacement and register base
      begin_prog();
      mem[0] = enc_c(OP_LD, 1, 31, 16'h0202);
      mem[1] = enc_c(6'h30, 2, 31, 16'h01F0);
      mem[2] = enc_c(OP_LD, 3, 2, 16'h0017);
      mem[3] = enc_c(OP_ST, 1, 31, 16'h0300);
      mem[4] = enc_c(OP_ST, 3, 31, 16'h0304);
      mem[128] = 32'hA5A5_1234;
      mem[129] = 32'h0BAD_F00D;
      run_prog();
      check("R8 load misaligned literal", mem[192], 32'hA5A5_1234);
      check("R8 load register base", mem[193], 32'h0BAD_F00D);

      // R9: store with low address bits set
      begin_prog();
      mem[0] = enc_c(6'h30, 1, 31, 16'd77);
      mem[1] = enc_c(OP_ST, 1, 31, 16'h030B);
      run_prog();
      check("R9 store aligned word", mem[194], 32'd77);
      check("R9 store neighbour below", mem[193], 32'd0);
      check("R9 store neighbour above", mem[195], 32'd0);

      // R11: register 31 discards writes and reads zero
      begin_prog();
      mem[0] = enc_c(6'h30, 31, 31, 16'd5);
      mem[1] = enc_c(OP_ST, 31, 31, 16'h0300);
      mem[2] = enc_c(6'h30, 2, 31, 16'd9);
      mem[3] = enc_c(OP_ST, 2, 31, 16'h0304);
      mem[192] = 32'hFFFF_FFFF;
      run_prog();
      check("R11 zero register after write", mem[192], 32'd0);
      check("R11 absolute base", mem[193], 32'd9);

      // R10: taken forward branch, not-taken branch, link values
      begin_prog();
      mem[0] = enc_c(6'h30, 6, 31, 16'd7);
      mem[1] = enc_c(6'h30, 1, 31, 16'd0);
      mem[2] = enc_c(OP_BEQ, 5, 1, 16'd1);
      mem[3] = enc_c(6'h30, 6, 31, 16'd99);
      mem[4] = enc_c(OP_BNE, 7, 1, 16'd5);
      mem[5] = enc_c(OP_ST, 5, 31, 16'h0300);
      mem[6] = enc_c(OP_ST, 7, 31, 16'h0304);
      mem[7] = enc_c(OP_ST, 6, 31, 16'h0308);
      run_prog();
      check("R10 link of taken branch", mem[192], 32'd12);
      check("R10 link of untaken branch", mem[193], 32'd20);
      check("R10 skipped instruction", mem[194], 32'd7);

      // R10 R2: backward loop
      begin_prog();
      mem[0] = enc_c(6'h30, 1, 31, 16'd3);
      mem[1] = enc_c(6'h30, 2, 31, 16'd0);
      mem[2] = enc_c(6'h30, 2, 2, 16'd1);
      mem[3] = enc_c(6'h31, 1, 1, 16'd1);
      mem[4] = enc_c(OP_BNE, 9, 1, 16'hFFFD);
      mem[5] = enc_c(OP_ST, 2, 31, 16'h0300);
      mem[6] = enc_c(OP_ST, 9, 31, 16'h0304);
      run_prog();
      check("R10 backward loop count", mem[192], 32'd3);
      check("R10 loop link", mem[193], 32'd20);

      // R12: halt on unknown opcode, later store never happens
      begin_prog();
      mem[0] = enc_c(6'h30, 1, 31, 16'd5);
      mem[1] = {6'h2F, 26'h0};
      mem[2] = enc_c(OP_ST, 1, 31, 16'h0300);
      mem[192] = 32'hDEAD_BEEF;
      run_prog();
      repeat (12) @(negedge clk);
      check("R12 halt held", {31'b0, halted}, 32'd1);
      check("R12 store after halt", mem[192], 32'hDEAD_BEEF);
      check("R12 writes while halted", halt_we, 32'd0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R12 watchdog expired: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule